// File: doc/BRIEF.md
# Programming Address Pointer

This block keeps the address counter that a serial programming engine uses while a device is held in programming mode. Entering the mode is a synchronous reset that clears the counter. A single-cycle increment strobe advances it, and a single-cycle configuration strobe jumps it to the base of configuration space. The command decoder drives these strobes. The memory arrays, the erase logic and the program logic read the counter's views from registered outputs.

The counter's 14-bit logical value is split into several views. The program array view keeps the low 12 bits, so user addresses above the 4K array alias back onto it. The configuration view reports a window offset and flags whether the address lies in the implemented window and whether it lies in the usable part of that window. The data-memory view keeps the low 8 bits. The top bit marks configuration space. Once that bit is set, it is kept until the next mode entry. Because of this, the counter wraps inside configuration space and never returns to user space.

Top module: `prog_addr_ptr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the logical address becomes 0x0000 after that edge, and every derived output takes the value that address implies.
- R2: A configuration strobe sets the logical address to 0x2000, whatever the previous address was.
- R3: In user space (bit 13 clear), an increment strobe adds one to the address. From 0x1FFF it steps to 0x2000.
- R4: In configuration space (bit 13 set), bit 13 stays set until reset. An increment from 0x3FFF gives 0x2000, and `cfg_space_o` never falls without a reset.
- R5: `phys_addr_o` equals bits 11:0 of the logical address. Logical 0x1000 therefore reaches physical 0x000, and configuration addresses above 0x201F also reach the user array through these bits.
- R6: `cfg_valid_o` is high exactly for logical addresses 0x2000 to 0x201F. In that range `cfg_addr_o` is bits 4:0 of the address; otherwise it is zero.
- R7: `cfg_usable_o` is high exactly for logical addresses 0x2000 to 0x2008.
- R8: `data_addr_o` equals bits 7:0 of the logical address.
- R9: When both strobes are high in the same cycle, the configuration strobe wins and the address becomes 0x2000.
- R10: With neither strobe high, the address and all derived outputs stay unchanged.
- R11: All outputs are registered. A strobe sampled at a rising edge changes the outputs only after that edge, and no output follows the strobe inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, asserted on programming-mode entry |
| inc_i | input | 1 | Single-cycle increment strobe |
| ldcfg_i | input | 1 | Single-cycle jump-to-configuration strobe |
| addr_o | output | 14 | Logical address |
| phys_addr_o | output | 12 | Program array address |
| cfg_space_o | output | 1 | High while the counter is in configuration space |
| cfg_valid_o | output | 1 | Address lies in the implemented configuration window |
| cfg_addr_o | output | 5 | Offset inside the configuration window (zero when not valid) |
| cfg_usable_o | output | 1 | Address lies in the usable configuration locations |
| data_addr_o | output | 8 | Data-memory address |

## Verification
The hardest states to reach from the ports are the two far ends of the count. The first is the step from 0x1FFF into configuration space. The second is the wrap from 0x3FFF back to 0x2000. Each end lies 8191 increments away from the only values the block can be forced to, which are 0x0000 and 0x2000. The bench reaches both with long runs of increment strobes, checking at the user aliasing point 0x1000 on the way. It then confirms at the ports that neither a further increment nor a full wrap brings the counter back into user space.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;

  // Action chosen for the counter in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_CFG  = 2'd2
  } ptr_act_e;

endpackage

// File: rtl/prog_addr_sel.sv
module prog_addr_sel
  import prog_addr_pkg::*;
(
  input  logic     inc_i,
  input  logic     ldcfg_i,
  output ptr_act_e act_o
);

  // The configuration jump has priority over the increment.
  always_comb begin
    if (ldcfg_i)    act_o = ACT_CFG;
    else if (inc_i) act_o = ACT_STEP;
    else            act_o = ACT_HOLD;
  end

endmodule

// File: rtl/prog_addr_next.sv
module prog_addr_next
  import prog_addr_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  ptr_act_e          act_i,
  output logic [ADDR_W-1:0] nxt_o
);

  localparam int                CFG_BIT  = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] CFG_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] stepped;

  // The space bit is sticky: once set, a carry out of the low bits cannot clear it.
  always_comb begin
    sum     = cur_i + ONE;
    stepped = {cur_i[CFG_BIT] | sum[CFG_BIT], sum[CFG_BIT-1:0]};
  end

  always_comb begin
    unique case (act_i)
      ACT_CFG:  nxt_o = CFG_BASE;
      ACT_STEP: nxt_o = stepped;
      default:  nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/prog_addr_view.sv
module prog_addr_view #(
  parameter int ADDR_W       = 14,
  parameter int PHYS_W       = 12,
  parameter int DATA_W       = 8,
  parameter int CFG_WIN_W    = 5,
  parameter int CFG_USABLE_N = 9
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [PHYS_W-1:0]    phys_o,
  output logic                 space_o,
  output logic                 valid_o,
  output logic [CFG_WIN_W-1:0] off_o,
  output logic                 usable_o,
  output logic [DATA_W-1:0]    data_o
);

  localparam int                   CFG_BIT = ADDR_W - 1;
  localparam int                   MID_W   = CFG_BIT - CFG_WIN_W;
  localparam logic [CFG_WIN_W-1:0] USE_LIM = CFG_WIN_W'(CFG_USABLE_N);

  logic in_window;

  always_comb begin
    in_window = addr_i[CFG_BIT] && (addr_i[CFG_BIT-1:CFG_WIN_W] == {MID_W{1'b0}});
    phys_o    = addr_i[PHYS_W-1:0];
    data_o    = addr_i[DATA_W-1:0];
    space_o   = addr_i[CFG_BIT];
    valid_o   = in_window;
    off_o     = in_window ? addr_i[CFG_WIN_W-1:0] : {CFG_WIN_W{1'b0}};
    usable_o  = in_window && (addr_i[CFG_WIN_W-1:0] < USE_LIM);
  end

endmodule

// File: rtl/prog_addr_ptr.sv
module prog_addr_ptr
  import prog_addr_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PHYS_W       = 12,
  parameter int DATA_W       = 8,
  parameter int CFG_WIN_W    = 5,
  parameter int CFG_USABLE_N = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inc_i,
  input  logic                 ldcfg_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [PHYS_W-1:0]    phys_addr_o,
  output logic                 cfg_space_o,
  output logic                 cfg_valid_o,
  output logic [CFG_WIN_W-1:0] cfg_addr_o,
  output logic                 cfg_usable_o,
  output logic [DATA_W-1:0]    data_addr_o
);

  localparam logic [ADDR_W-1:0]    CFG_BASE = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0]    TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [CFG_WIN_W-1:0] USE_LIM  = CFG_WIN_W'(CFG_USABLE_N);

  ptr_act_e              act;
  logic [ADDR_W-1:0]     nxt;
  logic [PHYS_W-1:0]     v_phys;
  logic                  v_space;
  logic                  v_valid;
  logic [CFG_WIN_W-1:0]  v_off;
  logic                  v_usable;
  logic [DATA_W-1:0]     v_data;

  prog_addr_sel u_sel (
    .inc_i   (inc_i),
    .ldcfg_i (ldcfg_i),
    .act_o   (act)
  );

  prog_addr_next #(.ADDR_W(ADDR_W)) u_next (
    .cur_i (addr_o),
    .act_i (act),
    .nxt_o (nxt)
  );

  // The views are decoded from the next value so that every output is a flop.
  prog_addr_view #(
    .ADDR_W       (ADDR_W),
    .PHYS_W       (PHYS_W),
    .DATA_W       (DATA_W),
    .CFG_WIN_W    (CFG_WIN_W),
    .CFG_USABLE_N (CFG_USABLE_N)
  ) u_view (
    .addr_i   (rst ? {ADDR_W{1'b0}} : nxt),
    .phys_o   (v_phys),
    .space_o  (v_space),
    .valid_o  (v_valid),
    .off_o    (v_off),
    .usable_o (v_usable),
    .data_o   (v_data)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_o <= {ADDR_W{1'b0}};
    else     addr_o <= nxt;
    phys_addr_o  <= v_phys;
    cfg_space_o  <= v_space;
    cfg_valid_o  <= v_valid;
    cfg_addr_o   <= v_off;
    cfg_usable_o <= v_usable;
    data_addr_o  <= v_data;
  end

  // R1: mode entry clears the counter
  p_clear_r1: assert property (@(posedge clk) rst |=> (addr_o == {ADDR_W{1'b0}}));

  // R2 and R9: the configuration strobe lands on the base, even with an increment
  p_jump_r2: assert property (@(posedge clk) disable iff (rst)
    ldcfg_i |=> (addr_o == CFG_BASE));
  p_prio_r9: assert property (@(posedge clk) disable iff (rst)
    (ldcfg_i && inc_i) |=> (addr_o == CFG_BASE));

  // R3: a plain increment below the top adds one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ldcfg_i && addr_o != TOP_ADDR) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

  // R4: configuration space is never left, and the top wraps to the base
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_space_o |=> cfg_space_o);
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ldcfg_i && addr_o == TOP_ADDR) |=> (addr_o == CFG_BASE));

  // R5 and R8: the array views track the logical address
  p_phys_r5: assert property (@(posedge clk) disable iff (rst)
    phys_addr_o == addr_o[PHYS_W-1:0]);
  p_data_r8: assert property (@(posedge clk) disable iff (rst)
    data_addr_o == addr_o[DATA_W-1:0]);

  // R6 and R7: window flags nest inside configuration space
  p_valid_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_o |-> cfg_space_o);
  p_usable_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_usable_o |-> (cfg_valid_o && cfg_addr_o < USE_LIM));

  // R10: no strobe, no movement
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !ldcfg_i) |=> $stable(addr_o));

endmodule

// File: tb/prog_addr_ptr_bench.sv
module prog_addr_ptr_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc = 1'b0;
  logic        ldcfg = 1'b0;
  logic [13:0] addr;
  logic [11:0] phys;
  logic        cspace;
  logic        cvalid;
  logic [4:0]  caddr;
  logic        cusable;
  logic [7:0]  daddr;

  int n_chk = 0;
  int n_bad = 0;
  int exp_a = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_addr_ptr u_prog_addr_ptr (
    .clk          (clk),
    .rst          (rst),
    .inc_i        (inc),
    .ldcfg_i      (ldcfg),
    .addr_o       (addr),
    .phys_addr_o  (phys),
    .cfg_space_o  (cspace),
    .cfg_valid_o  (cvalid),
    .cfg_addr_o   (caddr),
    .cfg_usable_o (cusable),
    .data_addr_o  (daddr)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // Compare every output with values derived from the model address.
  task automatic chk_all(input string req);
    bit in_win;
    in_win = (exp_a >= 'h2000) && (exp_a <= 'h201F);
    chk(req, "addr", int'(addr), exp_a);
    chk(req, "phys R5", int'(phys), exp_a & 'hFFF);
    chk(req, "data R8", int'(daddr), exp_a & 'hFF);
    chk(req, "space R4", int'(cspace), int'(exp_a >= 'h2000));
    chk(req, "valid R6", int'(cvalid), int'(in_win));
    chk(req, "offset R6", int'(caddr), in_win ? (exp_a & 'h1F) : 0);
    chk(req, "usable R7", int'(cusable), int'(exp_a >= 'h2000 && exp_a <= 'h2008));
  endtask

  // One clock with the given strobes, starting and ending at a falling edge.
  task automatic cyc(input bit i, input bit l);
    inc = i;
    ldcfg = l;
    @(negedge clk);
    inc = 1'b0;
    ldcfg = 1'b0;
    if (l)      exp_a = 'h2000;
    else if (i) exp_a = (exp_a >= 'h2000) ? ('h2000 | ((exp_a + 1) & 'h1FFF)) : exp_a + 1;
  endtask

  task automatic run_inc(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_a = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_user_count();
    run_inc(3);
    chk_all("R3 small step");
    run_inc('h1000 - 3);
    chk_all("R5 alias 0x1000");
    chk("R5", "alias to zero", int'(phys), 0);
    run_inc('h0FFF);
    chk_all("R3 at 0x1FFF");
    run_inc(1);
    chk("R3", "step into cfg", int'(addr), 'h2000);
    chk_all("R3 after 0x1FFF");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0);
    chk_all("R10 hold");
  endtask

  task automatic t_cfg_window();
    do_reset();
    run_inc(5);
    cyc(1'b0, 1'b1);
    chk("R2", "jump", int'(addr), 'h2000);
    chk_all("R2 jump");
    for (int k = 0; k < 'h22; k++) begin
      chk_all("R7 window walk");
      cyc(1'b1, 1'b0);
    end
    chk_all("R6 beyond window");
    chk("R6", "invalid above 0x201F", int'(cvalid), 0);
  endtask

  task automatic t_cfg_wrap();
    run_inc('h3FFF - exp_a);
    chk_all("R4 at top");
    chk("R4", "top value", int'(addr), 'h3FFF);
    cyc(1'b1, 1'b0);
    chk("R4", "wrap", int'(addr), 'h2000);
    chk_all("R4 wrap");
  endtask

  task automatic t_priority();
    do_reset();
    run_inc(7);
    cyc(1'b1, 1'b1);
    chk("R9", "both strobes", int'(addr), 'h2000);
    chk_all("R9 both");
    run_inc(3);
    cyc(1'b0, 1'b1);
    chk_all("R2 rejump");
  endtask

  task automatic t_registered();
    do_reset();
    run_inc(2);
    inc = 1'b1;
    #1;
    chk("R11", "no comb path inc", int'(addr), 2);
    ldcfg = 1'b1;
    #1;
    chk("R11", "no comb path ldcfg", int'(cspace), 0);
    inc = 1'b0;
    ldcfg = 1'b0;
    @(negedge clk);
    chk_all("R11 idle after");
    do_reset();
    chk_all("R1 leave cfg by reset");
  endtask

  initial begin
    t_reset();
    t_user_count();
    t_hold();
    t_cfg_window();
    t_cfg_wrap();
    t_priority();
    t_registered();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule